// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic use an external 8K x 8 asynchronous static RAM. A host hands it one request at a time over a valid/ready handshake: a 13-bit address, a read/write flag and a byte of write data. The controller then produces the memory-side pins in a fixed sequence: address, two opposite-polarity chip selects, a write strobe, an output enable, and an 8-bit data bus split into output, drive-enable and input. A read returns its byte on a one-cycle response pulse.

Each phase lasts a number of clock cycles set by configuration inputs: the bus turnaround before data is driven, the write pulse, the read access and the closing hold. A mode input selects how a write ends. In strobe-ended mode the write strobe rises while the selects stay active. In select-ended mode both selects drop while the strobe is still low. Every access opens with one setup cycle in which the address is valid and the memory is deselected.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, req_ready is 1, mem_sel_n is 1, mem_sel is 0, mem_we_n is 1, mem_oe_n is 1 and mem_dq_oe is 0.
- R2: The memory is selected only as mem_sel_n = 0 together with mem_sel = 1. The two selects always switch on the same clock edge, so they are never both active-valued or both inactive-valued by mistake.
- R3: A read accepted at a clock edge gives 1 setup cycle (deselected, mem_we_n = 1, mem_oe_n = 1). It then gives t_rd cycles selected with mem_oe_n = 0 and mem_we_n = 1. The byte on mem_dq_i in the last of those cycles appears on rsp_rdata with rsp_valid = 1 during the first of t_hold deselected recovery cycles. Then the block is idle again.
- R4: A write accepted at a clock edge gives 1 setup cycle and then t_turn cycles selected with mem_we_n = 0, mem_oe_n = 1 and mem_dq_oe = 0, before any data is driven.
- R5: The turnaround is followed by t_wr cycles selected with mem_we_n = 0 and mem_dq_oe = 1, with the write byte on mem_dq_o.
- R6: With cfg_wr_mode = 0 (strobe-ended), the write ends by mem_we_n rising while selected. The following t_hold cycles keep the selects active, mem_we_n = 1 and the data driven.
- R7: With cfg_wr_mode = 1 (select-ended), the write ends by both selects going inactive while mem_we_n stays 0. The following t_hold cycles keep mem_we_n = 0 and the data driven.
- R8: mem_addr does not change while the memory is selected or mem_we_n is 0, and mem_dq_o does not change while mem_dq_oe stays 1.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_oe_n is never 0 while mem_we_n is 0.
- R10: req_ready is 0 for the whole access, and a request offered while req_ready is 0 is ignored: it changes neither the pin sequence nor the memory.
- R11: A configured cycle count of 0 is treated as 1.
- R12: rsp_valid is never high on two consecutive cycles and is never high while req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_mode | input | 1 | Write end style: 0 strobe-ended, 1 select-ended; taken at acceptance |
| cfg_t_turn | input | CNT_W | Turnaround cycles before driving data |
| cfg_t_wr | input | CNT_W | Write data window cycles |
| cfg_t_rd | input | CNT_W | Read access cycles |
| cfg_t_hold | input | CNT_W | Closing hold/recovery cycles |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DW | Read byte |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | DW | Data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW | Data from memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
All pins are registered, so the first setup cycle is seen one cycle after the accepting edge. Each later phase follows after exactly the configured number of cycles, with 0 counted as 1. The read response is due in the first recovery cycle, 2 + t_rd cycles after acceptance. For every accepted request, the bench pushes the expected pin tuple for each of those cycles into a queue. At every falling clock edge it pops one tuple and compares it, so every phase boundary is checked in the cycle it is due. A memory model in the bench stores bytes only at the terminating edge of the selected write style, and reading back through the host side confirms which edge ended each write.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the asynchronous SRAM access controller.
// Assumes: one access in flight at a time; pins decoded from the sequencer state.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD_ACC,
        ST_WR_TURN,
        ST_WR_DATA,
        ST_WR_HOLD,
        ST_RD_HOLD
    } seq_state_e;

    typedef struct packed {
        logic ready;
        logic sel;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_set_t;

    // Pin levels for a sequencer state; sel_end picks select-ended write hold.
    function automatic pin_set_t pins_for(seq_state_e s, logic sel_end);
        pin_set_t p;
        p = '{ready: 1'b0, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (s)
            ST_IDLE:    p.ready = 1'b1;
            ST_SETUP:   ;
            ST_RD_ACC:  begin p.sel = 1'b1; p.oe_n = 1'b0; end
            ST_WR_TURN: begin p.sel = 1'b1; p.we_n = 1'b0; end
            ST_WR_DATA: begin p.sel = 1'b1; p.we_n = 1'b0; p.drive = 1'b1; end
            ST_WR_HOLD: begin
                p.drive = 1'b1;
                p.sel   = !sel_end;
                p.we_n  = !sel_end;
            end
            ST_RD_HOLD: ;
            default:    ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Phase timer: loaded with a cycle count on entry to a phase, flags the
// last cycle of that phase. Assumes: a count of 0 means 1.
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Load the phase length (clamped to 1) or count down toward 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ONE;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? ONE : load_val;
        end else if (cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

endmodule

// File: rtl/sram_ctrl_seq.sv
// Access sequencer: walks setup, access, turnaround, data and hold phases.
// Assumes: start only pulses while idle; is_write is stable during an access.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [CNT_W-1:0] t_turn,
    input  logic [CNT_W-1:0] t_wr,
    input  logic [CNT_W-1:0] t_rd,
    input  logic [CNT_W-1:0] t_hold,
    output seq_state_e       state_next,
    output logic             capture
);

    seq_state_e       state_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    // Next phase, timer reload and read capture strobe.
    always_comb begin
        state_next = state_q;
        tmr_load   = 1'b0;
        tmr_val    = t_hold;
        capture    = 1'b0;
        case (state_q)
            ST_IDLE: if (start) state_next = ST_SETUP;
            ST_SETUP: begin
                tmr_load   = 1'b1;
                state_next = is_write ? ST_WR_TURN : ST_RD_ACC;
                tmr_val    = is_write ? t_turn : t_rd;
            end
            ST_RD_ACC: if (tmr_last) begin
                state_next = ST_RD_HOLD;
                tmr_load   = 1'b1;
                capture    = 1'b1;
            end
            ST_WR_TURN: if (tmr_last) begin
                state_next = ST_WR_DATA;
                tmr_load   = 1'b1;
                tmr_val    = t_wr;
            end
            ST_WR_DATA: if (tmr_last) begin
                state_next = ST_WR_HOLD;
                tmr_load   = 1'b1;
            end
            ST_WR_HOLD, ST_RD_HOLD: if (tmr_last) state_next = ST_IDLE;
            default: state_next = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_next;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous SRAM access controller. Captures one host request,
// runs the sequencer and registers every memory pin so none can glitch.
// Assumes: the memory drives mem_dq_i only while selected with OE low and WE high.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW    = 13,
    parameter int DW    = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_mode,
    input  logic [CNT_W-1:0] cfg_t_turn,
    input  logic [CNT_W-1:0] cfg_t_wr,
    input  logic [CNT_W-1:0] cfg_t_rd,
    input  logic [CNT_W-1:0] cfg_t_hold,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dq_o,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_i,
    output logic             mem_sel_n,
    output logic             mem_sel,
    output logic             mem_we_n,
    output logic             mem_oe_n
);

    localparam pin_set_t IDLE_PINS =
        '{ready: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    seq_state_e state_next;
    logic       capture;
    logic       accept;
    logic       write_q;
    logic       sel_end_q;
    pin_set_t   pins_q;
    pin_set_t   pins_d;

    assign accept = req_valid && pins_q.ready;

    sram_ctrl_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .is_write   (write_q),
        .t_turn     (cfg_t_turn),
        .t_wr       (cfg_t_wr),
        .t_rd       (cfg_t_rd),
        .t_hold     (cfg_t_hold),
        .state_next (state_next),
        .capture    (capture)
    );

    // The access kind and write style become known at acceptance.
    always_comb pins_d = pins_for(state_next, accept ? cfg_wr_mode : sel_end_q);

    // Latch the request fields once, at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q   <= 1'b0;
            sel_end_q <= 1'b0;
            mem_addr  <= '0;
            mem_dq_o  <= '0;
        end else if (accept) begin
            write_q   <= req_write;
            sel_end_q <= cfg_wr_mode;
            mem_addr  <= req_addr;
            mem_dq_o  <= req_wdata;
        end
    end

    // Register the pin levels of the coming phase.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= IDLE_PINS;
        else        pins_q <= pins_d;
    end

    // Sample read data at the end of the access phase and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= mem_dq_i;
        end
    end

    assign req_ready = pins_q.ready;
    assign mem_sel   = pins_q.sel;
    assign mem_sel_n = !pins_q.sel;
    assign mem_we_n  = pins_q.we_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_dq_oe = pins_q.drive;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Protocol checker for the SRAM access controller, bound to its top.
module sram_async_ctrl_chk #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe,
    input logic          mem_sel_n,
    input logic          mem_sel,
    input logic          mem_we_n,
    input logic          mem_oe_n
);

    logic selected;
    assign selected = !mem_sel_n && mem_sel;

    a_r2_sel_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n != mem_sel);

    a_r9_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r9_no_oe_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (selected || !mem_we_n) |-> $stable(mem_addr));

    a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r12_valid_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!selected && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/sram_async_ctrl_tb.sv
// Bench: queue-based expected pin model plus a behavioural memory device.
module sram_async_ctrl_tb;

    localparam int AW = 13;
    localparam int DW = 8;
    localparam int CW = 4;

    typedef struct {
        bit         ready;
        bit         sel;
        bit         we_n;
        bit         oe_n;
        bit         drv;
        bit         rv;
        logic [7:0] rdata;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_mode = 1'b0;
    logic [CW-1:0] cfg_t_turn = 4'd1, cfg_t_wr = 4'd1, cfg_t_rd = 4'd1, cfg_t_hold = 4'd1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, mem_dq_oe, mem_sel_n, mem_sel, mem_we_n, mem_oe_n;
    logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    logic [7:0] dev_mem[int];
    logic [7:0] gold[int];
    logic [AW-1:0] cur_addr;
    logic [7:0]    cur_data;

    always #5 clk = ~clk;

    sram_async_ctrl #(.AW(AW), .DW(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_mode(cfg_wr_mode),
        .cfg_t_turn(cfg_t_turn), .cfg_t_wr(cfg_t_wr), .cfg_t_rd(cfg_t_rd),
        .cfg_t_hold(cfg_t_hold), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n)
    );

    // Behavioural memory device: reads combinationally, writes on the ending edge.
    logic dev_sel;
    assign dev_sel  = !mem_sel_n && mem_sel;
    assign mem_dq_i = (dev_sel && mem_we_n && !mem_oe_n) ?
                      (dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 8'h00) : 8'h00;

    always @(posedge mem_we_n) begin
        if (dev_sel) begin
            checks++;
            if (cfg_wr_mode !== 1'b0 || !mem_dq_oe) begin
                fails++;
                $display("FAIL R6: strobe-ended write edge, mode=%0b drive=%0b expected mode=0 drive=1",
                         cfg_wr_mode, mem_dq_oe);
            end
            dev_mem[int'(mem_addr)] = mem_dq_o;
        end
    end

    always @(negedge dev_sel) begin
        if (!mem_we_n) begin
            checks++;
            if (cfg_wr_mode !== 1'b1 || !mem_dq_oe) begin
                fails++;
                $display("FAIL R7: select-ended write edge, mode=%0b drive=%0b expected mode=1 drive=1",
                         cfg_wr_mode, mem_dq_oe);
            end
            dev_mem[int'(mem_addr)] = mem_dq_o;
        end
    end

    function automatic int eff(logic [CW-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic exp_t mk(bit rdy, bit s, bit we, bit oe, bit d, bit rv,
                                logic [7:0] rd, string tag);
        exp_t e;
        e.ready = rdy; e.sel = s; e.we_n = we; e.oe_n = oe; e.drv = d;
        e.rv = rv; e.rdata = rd; e.tag = tag;
        return e;
    endfunction

    // One clock: compare the pins against the next expected tuple.
    task automatic step();
        exp_t e;
        @(negedge clk);
        e = (q.size() != 0) ? q.pop_front() : mk(1, 0, 1, 1, 0, 0, 8'h00, "R1");
        checks++;
        if (req_ready !== e.ready || mem_sel !== e.sel || mem_sel_n !== !e.sel ||
            mem_we_n !== e.we_n || mem_oe_n !== e.oe_n || mem_dq_oe !== e.drv ||
            rsp_valid !== e.rv) begin
            fails++;
            $display("FAIL %s: pins rdy=%b sel=%b sel_n=%b we_n=%b oe_n=%b oe=%b rv=%b expected rdy=%b sel=%b sel_n=%b we_n=%b oe_n=%b oe=%b rv=%b",
                     e.tag, req_ready, mem_sel, mem_sel_n, mem_we_n, mem_oe_n, mem_dq_oe,
                     rsp_valid, e.ready, e.sel, !e.sel, e.we_n, e.oe_n, e.drv, e.rv);
        end
        if (!e.ready) begin
            checks++;
            if (mem_addr !== cur_addr || (e.drv && mem_dq_o !== cur_data)) begin
                fails++;
                $display("FAIL R8: addr=%h data=%h expected addr=%h data=%h",
                         mem_addr, mem_dq_o, cur_addr, cur_data);
            end
        end
        if (e.rv) begin
            checks++;
            if (rsp_rdata !== e.rdata) begin
                fails++;
                $display("FAIL R3: rsp_rdata=%h expected %h", rsp_rdata, e.rdata);
            end
        end
    endtask

    // Issue one request from an idle cycle and check its full pin sequence.
    task automatic issue(bit wr, logic [AW-1:0] a, logic [7:0] d, bit noise);
        logic [7:0] rexp;
        rexp = gold.exists(int'(a)) ? gold[int'(a)] : 8'h00;
        cur_addr = a;
        cur_data = d;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        q.push_back(mk(0, 0, 1, 1, 0, 0, 0, wr ? "R4" : "R3"));
        if (wr) begin
            for (int i = 0; i < eff(cfg_t_turn); i++) q.push_back(mk(0, 1, 0, 1, 0, 0, 0, "R4"));
            for (int i = 0; i < eff(cfg_t_wr); i++)   q.push_back(mk(0, 1, 0, 1, 1, 0, 0, "R5"));
            for (int i = 0; i < eff(cfg_t_hold); i++)
                q.push_back(cfg_wr_mode ? mk(0, 0, 0, 1, 1, 0, 0, "R7")
                                        : mk(0, 1, 1, 1, 1, 0, 0, "R6"));
            gold[int'(a)] = d;
        end else begin
            for (int i = 0; i < eff(cfg_t_rd); i++) q.push_back(mk(0, 1, 1, 0, 0, 0, 0, "R3"));
            q.push_back(mk(0, 0, 1, 1, 0, 1, rexp, "R3"));
            for (int i = 1; i < eff(cfg_t_hold); i++) q.push_back(mk(0, 0, 1, 1, 0, 0, 0, "R12"));
        end
        step();
        req_valid = 1'b0;
        if (noise) begin
            // R10: a request offered while busy must be ignored.
            req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0AAA; req_wdata = 8'hEE;
            step();
            req_valid = 1'b0;
        end
        while (q.size() != 0) step();
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || mem_sel_n !== 1'b1 || mem_sel !== 1'b0 ||
            mem_we_n !== 1'b1 || mem_oe_n !== 1'b1 || mem_dq_oe !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset pins rdy=%b sel_n=%b sel=%b we_n=%b oe_n=%b oe=%b expected 1 1 0 1 1 0",
                     req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe);
        end
        rst_n = 1'b1;
        step();

        // Strobe-ended writes, then read back (R3, R4, R5, R6).
        cfg_wr_mode = 1'b0;
        cfg_t_turn = 4'd2; cfg_t_wr = 4'd3; cfg_t_rd = 4'd2; cfg_t_hold = 4'd2;
        issue(1, 13'h0001, 8'h5A, 0);
        issue(1, 13'h1FFF, 8'hC3, 0);
        issue(0, 13'h0001, 8'h00, 0);
        issue(0, 13'h1FFF, 8'h00, 0);

        // Select-ended writes with other timings (R7).
        cfg_wr_mode = 1'b1;
        cfg_t_turn = 4'd1; cfg_t_wr = 4'd4; cfg_t_rd = 4'd3; cfg_t_hold = 4'd3;
        issue(1, 13'h0123, 8'h96, 0);
        issue(1, 13'h0000, 8'hFF, 0);
        issue(0, 13'h0123, 8'h00, 0);
        issue(0, 13'h0000, 8'h00, 0);

        // R10: busy-time request ignored, memory at 0x0AAA unchanged.
        cfg_t_rd = 4'd5;
        issue(0, 13'h0AAA, 8'h00, 1);
        issue(0, 13'h0AAA, 8'h00, 0);

        // R11: zero counts behave as one.
        cfg_wr_mode = 1'b0;
        cfg_t_turn = 4'd0; cfg_t_wr = 4'd0; cfg_t_rd = 4'd0; cfg_t_hold = 4'd0;
        issue(1, 13'h0AAA, 8'h3C, 0);
        issue(0, 13'h0AAA, 8'h00, 0);
        cfg_wr_mode = 1'b1;
        issue(1, 13'h0555, 8'hA5, 0);
        issue(0, 13'h0555, 8'h00, 0);

        // Longest timings (R12 across a long recovery).
        cfg_t_turn = 4'd15; cfg_t_wr = 4'd15; cfg_t_rd = 4'd15; cfg_t_hold = 4'd15;
        issue(1, 13'h1000, 8'h81, 0);
        issue(0, 13'h1000, 8'h00, 0);
        repeat (3) step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule